// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

A single DMA channel that moves data between a device-side request/acknowledge port and memory. It walks a closed ring of descriptors in memory: every descriptor names a byte count, a buffer address and the address of the following descriptor. The last descriptor points back to the first, so once started the channel streams without end until it is told to abort.

Software-facing setup is reduced to plain inputs. These are the ring base address, the transfer direction, and the memory and device port widths. A start pulse clears the device byte counter, loads the link address from the ring base and begins fetching. Each descriptor is read as three 32-bit words, then its buffer is moved one device-width beat at a time. Each beat is one device handshake and one memory access, in the order the direction implies. When the count runs out, a one-cycle link event is raised and the next descriptor fetch begins in that same cycle.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `link_done_o` and all request outputs are low and `dev_count_o` is zero.
- R2: `cfg_err_o` is high whenever either width input is not 8, 16 or 32. A start pulse while `cfg_err_o` is high leaves the channel idle.
- R3: `swap_o` is high exactly when the memory width is 32 and the device width is 16. Data then crosses with the two bytes of each 16-bit half exchanged: out = {in[23:16], in[31:24], in[7:0], in[15:8]}. Otherwise data passes unchanged.
- R4: A start begins with a memory read at the ring base in the following cycle. Each descriptor is read as three 32-bit words at link+0 (count), link+4 (buffer address) and link+8 (next link).
- R5: With `dir_in_i` high (device to memory), each beat is a device handshake whose `dev_rdata_i` word is then written to memory at the current buffer address. The address advances by the beat size, which is the device width divided by 8.
- R6: With `dir_in_i` low (memory to device), each beat is a memory read at the current buffer address followed by a device handshake that presents the read word on `dev_wdata_o`.
- R7: The remaining count drops by the beat size on each beat, and the beat that brings it to or below zero is the last one. `link_done_o` then pulses for one cycle, and in that cycle `mem_rd_req_o` is already high for the next descriptor.
- R8: A descriptor with a zero count moves no data, pulses `link_done_o` and hands over to its next descriptor.
- R9: `dev_count_o` is cleared by an accepted start and grows by the beat size on every device handshake.
- R10: An abort pulse stops the channel at the next beat boundary. A beat past its first handshake is completed, and once `busy_o` falls no request is raised until the next start.
- R11: The channel follows the next pointers around the ring indefinitely, returning to the first descriptor after the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Abort pulse |
| ring_base_i | input | AW | Address of the first descriptor |
| dir_in_i | input | 1 | 1: device to memory, 0: memory to device |
| mem_width_i | input | WW | Memory port width in bits |
| dev_width_i | input | WW | Device port width in bits |
| cfg_err_o | output | 1 | Illegal width selected |
| swap_o | output | 1 | Byte exchange active |
| busy_o | output | 1 | Channel running |
| link_done_o | output | 1 | One-cycle descriptor completion pulse |
| dev_count_o | output | AW | Bytes moved on the device side since start |
| mem_rd_req_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | AW | Memory read address |
| mem_rd_ack_i | input | 1 | Memory read accepted, data valid |
| mem_rd_data_i | input | 32 | Memory read data |
| mem_wr_req_o | output | 1 | Memory write request |
| mem_wr_addr_o | output | AW | Memory write address |
| mem_wr_data_o | output | 32 | Memory write data |
| mem_wr_ack_i | input | 1 | Memory write accepted |
| dev_req_o | output | 1 | Device transfer request |
| dev_wdata_o | output | 32 | Data to the device |
| dev_ack_i | input | 1 | Device handshake accepted |
| dev_rdata_i | input | 32 | Data from the device, valid with the acknowledge |

## Verification
The assertions take for granted that every acknowledge arrives only while its own request is high. They also assume that direction and widths are held steady for as long as the channel is busy. The bench responders raise an acknowledge only on a cycle where they see the matching request. They never hold it for two cycles in a row. Configuration is changed only after `busy_o` has fallen or before the start pulse.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int DW        = 32;
  localparam int WORD_B    = 4;
  localparam int DESC_WRDS = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_PH1, ST_PH2} st_e;

  function automatic logic [DW-1:0] half_swap(input logic [DW-1:0] d);
    return {d[23:16], d[31:24], d[7:0], d[15:8]};
  endfunction
endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check #(
  parameter int WW = 6
) (
  input  logic [WW-1:0] mem_width_i,
  input  logic [WW-1:0] dev_width_i,
  output logic          cfg_err_o,
  output logic          swap_o,
  output logic [2:0]    beat_bytes_o
);
  function automatic logic legal(input logic [WW-1:0] w);
    return (w == WW'(8)) || (w == WW'(16)) || (w == WW'(32));
  endfunction

  assign cfg_err_o = !(legal(mem_width_i) && legal(dev_width_i));
  assign swap_o    = (mem_width_i == WW'(32)) && (dev_width_i == WW'(16));

  always_comb begin
    case (dev_width_i)
      WW'(8):  beat_bytes_o = 3'd1;
      WW'(16): beat_bytes_o = 3'd2;
      default: beat_bytes_o = 3'd4;
    endcase
  end
endmodule

// File: rtl/dma_dev_counter.sv
module dma_dev_counter #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [2:0]    step_i,
  output logic [AW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + AW'(step_i);
  end

  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + AW'($past(step_i))));
  assert_count_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
  import dma_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int WW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic          dir_in_i,
  input  logic [WW-1:0] mem_width_i,
  input  logic [WW-1:0] dev_width_i,
  output logic          cfg_err_o,
  output logic          swap_o,
  output logic          busy_o,
  output logic          link_done_o,
  output logic [AW-1:0] dev_count_o,
  output logic          mem_rd_req_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic          mem_rd_ack_i,
  input  logic [DW-1:0] mem_rd_data_i,
  output logic          mem_wr_req_o,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o,
  input  logic          mem_wr_ack_i,
  output logic          dev_req_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic          dev_ack_i,
  input  logic [DW-1:0] dev_rdata_i
);
  localparam int IDX_W = $clog2(DESC_WRDS);

  st_e             st_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]   link_q, cnt_q, buf_q, next_q;
  logic [DW-1:0]   data_q;
  logic            abort_q, link_q_pulse;
  logic [2:0]      beat_bytes;
  logic [AW-1:0]   beat;
  logic            stop, last, ph1_done, ph2_done, go, dev_hs;
  logic [DW-1:0]   src, src_x;

  dma_cfg_check #(.WW(WW)) u_cfg (
    .mem_width_i  (mem_width_i),
    .dev_width_i  (dev_width_i),
    .cfg_err_o    (cfg_err_o),
    .swap_o       (swap_o),
    .beat_bytes_o (beat_bytes)
  );

  assign beat     = AW'(beat_bytes);
  assign stop     = abort_i || abort_q;
  assign last     = cnt_q <= beat;
  assign go       = (st_q == ST_IDLE) && start_i && !cfg_err_o;

  assign busy_o        = st_q != ST_IDLE;
  assign link_done_o   = link_q_pulse;
  assign dev_req_o     = (st_q == ST_PH1 && dir_in_i) || (st_q == ST_PH2 && !dir_in_i);
  assign mem_rd_req_o  = (st_q == ST_FETCH) || (st_q == ST_PH1 && !dir_in_i);
  assign mem_rd_addr_o = (st_q == ST_FETCH) ? link_q + AW'({idx_q, 2'b00}) : buf_q;
  assign mem_wr_req_o  = (st_q == ST_PH2) && dir_in_i;
  assign mem_wr_addr_o = buf_q;
  assign mem_wr_data_o = data_q;
  assign dev_wdata_o   = data_q;

  assign ph1_done = dir_in_i ? dev_ack_i : mem_rd_ack_i;
  assign ph2_done = dir_in_i ? mem_wr_ack_i : dev_ack_i;
  assign dev_hs   = dev_req_o && dev_ack_i;
  assign src      = dir_in_i ? dev_rdata_i : mem_rd_data_i;
  assign src_x    = swap_o ? half_swap(src) : src;

  dma_dev_counter #(.AW(AW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go),
    .inc_i  (dev_hs),
    .step_i (beat_bytes),
    .cnt_o  (dev_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      idx_q        <= '0;
      link_q       <= '0;
      cnt_q        <= '0;
      buf_q        <= '0;
      next_q       <= '0;
      data_q       <= '0;
      abort_q      <= 1'b0;
      link_q_pulse <= 1'b0;
    end else begin
      link_q_pulse <= 1'b0;
      if (abort_i && st_q != ST_IDLE) abort_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          abort_q <= 1'b0;
          if (go) begin
            st_q   <= ST_FETCH;
            idx_q  <= '0;
            link_q <= ring_base_i;
          end
        end
        ST_FETCH: begin
          if (stop) begin
            st_q <= ST_IDLE;
          end else if (mem_rd_ack_i) begin
            case (idx_q)
              IDX_W'(0): cnt_q  <= AW'(mem_rd_data_i);
              IDX_W'(1): buf_q  <= AW'(mem_rd_data_i);
              default:   next_q <= AW'(mem_rd_data_i);
            endcase
            if (idx_q == IDX_W'(DESC_WRDS - 1)) begin
              idx_q <= '0;
              if (cnt_q == '0) begin
                link_q_pulse <= 1'b1;
                link_q       <= AW'(mem_rd_data_i);
              end else begin
                st_q <= ST_PH1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PH1: begin
          if (ph1_done) begin
            data_q <= src_x;
            st_q   <= ST_PH2;
          end else if (stop) begin
            st_q <= ST_IDLE;
          end
        end
        default: begin
          if (ph2_done) begin
            buf_q <= buf_q + beat;
            if (last) begin
              cnt_q        <= '0;
              link_q_pulse <= 1'b1;
              link_q       <= next_q;
              st_q         <= stop ? ST_IDLE : ST_FETCH;
            end else begin
              cnt_q <= cnt_q - beat;
              st_q  <= stop ? ST_IDLE : ST_PH1;
            end
          end
        end
      endcase
    end
  end

  // input-side assumptions
  assert_ack_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_ack_i |-> mem_wr_req_o) and (mem_rd_ack_i |-> mem_rd_req_o));
  assert_cfg_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(dir_in_i) && $stable(mem_width_i) && $stable(dev_width_i)));
  // behaviour
  assert_start_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cfg_err_o) |=> !busy_o);
  assert_link_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_done_o |=> !link_done_o);
  assert_link_fetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_done_o && busy_o) |-> mem_rd_req_o);
  assert_stop_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(abort_i || abort_q));
endmodule

// File: tb/tb_dma_ring_engine.sv
module tb_dma_ring_engine;
  localparam int AW = 32;
  localparam int WW = 6;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start_i = 0, abort_i = 0, dir_in = 0;
  logic [WW-1:0] mem_w = 6'd32, dev_w = 6'd32;
  logic          cfg_err, swap, busy, link_done;
  logic [AW-1:0] dev_count, rd_addr, wr_addr;
  logic          rd_req, wr_req, dev_req;
  logic          rd_ack = 0, wr_ack = 0, dev_ack = 0;
  logic [31:0]   rd_data = 0, wr_data, dev_wdata, dev_rdata = 0;

  dma_ring_engine #(.AW(AW), .WW(WW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .abort_i(abort_i),
    .ring_base_i(BASE), .dir_in_i(dir_in), .mem_width_i(mem_w), .dev_width_i(dev_w),
    .cfg_err_o(cfg_err), .swap_o(swap), .busy_o(busy), .link_done_o(link_done),
    .dev_count_o(dev_count),
    .mem_rd_req_o(rd_req), .mem_rd_addr_o(rd_addr), .mem_rd_ack_i(rd_ack), .mem_rd_data_i(rd_data),
    .mem_wr_req_o(wr_req), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data), .mem_wr_ack_i(wr_ack),
    .dev_req_o(dev_req), .dev_wdata_o(dev_wdata), .dev_ack_i(dev_ack), .dev_rdata_i(dev_rdata)
  );

  int checks = 0, fails = 0, cycles = 0;
  int b = 4, mdesc = 0, moff = 0, exp_links = 0, obs_links = 0, nd = 0, nw = 0, fidx = 0;
  bit sw = 0;
  logic [31:0] fbase = 0;
  int unsigned dcnt [3] = '{8, 0, 6};
  logic [31:0] dbuf [3] = '{32'h400, 32'h600, 32'h800};

  function automatic logic [31:0] fmem(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] gdev(input int k);
    return k * 32'h01030507 + 32'h11;
  endfunction
  function automatic logic [31:0] sw16(input logic [31:0] d);
    return {d[23:16], d[31:24], d[7:0], d[15:8]};
  endfunction
  function automatic bit in_ring(input logic [31:0] a);
    return a >= BASE && a < BASE + 36;
  endfunction
  function automatic logic [31:0] desc_word(input logic [31:0] a);
    int j = int'((a - BASE) / 12);
    int w = int'(((a - BASE) % 12) / 4);
    case (w)
      0: return dcnt[j];
      1: return dbuf[j];
      default: return BASE + 12 * ((j + 1) % 3);
    endcase
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask
  task automatic skip_zero();
    while (dcnt[mdesc] == 0) begin
      exp_links++;
      mdesc = (mdesc + 1) % 3;
    end
  endtask
  task automatic advance();
    moff++;
    if (moff * b >= int'(dcnt[mdesc])) begin
      exp_links++;
      mdesc = (mdesc + 1) % 3;
      moff = 0;
    end
  endtask
  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog R11: actual %0d expected below 150000", cycles);
      summary();
      $finish;
    end
  end

  // responders and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ma, ex;
      if (!busy && (rd_req || wr_req || dev_req)) check(0, "R10", {29'b0, rd_req, wr_req, dev_req}, 0);
      if (link_done) begin
        obs_links++;
        if (busy) check(rd_req && in_ring(rd_addr) && ((rd_addr - BASE) % 12 == 0), "R7", rd_addr, BASE);
      end
      rd_ack = rd_req && !rd_ack;
      if (rd_ack) begin
        if (in_ring(rd_addr)) begin
          if (fidx == 0) fbase = rd_addr;
          check(rd_addr == fbase + 4 * fidx && ((fbase - BASE) % 12 == 0), "R4", rd_addr, fbase + 4 * fidx);
          fidx = (fidx + 1) % 3;
          rd_data = desc_word(rd_addr);
        end else begin
          skip_zero();
          ma = dbuf[mdesc] + moff * b;
          check(rd_addr == ma, "R6", rd_addr, ma);
          rd_data = fmem(rd_addr);
        end
      end
      wr_ack = wr_req && !wr_ack;
      if (wr_ack) begin
        skip_zero();
        ma = dbuf[mdesc] + moff * b;
        check(wr_addr == ma, "R5", wr_addr, ma);
        ex = sw ? sw16(gdev(nw)) : gdev(nw);
        check(wr_data == ex, sw ? "R3" : "R5", wr_data, ex);
        nw++;
        advance();
      end
      dev_ack = dev_req && !dev_ack;
      if (dev_ack) begin
        if (dir_in) begin
          dev_rdata = gdev(nd);
        end else begin
          skip_zero();
          ma = dbuf[mdesc] + moff * b;
          ex = sw ? sw16(fmem(ma)) : fmem(ma);
          check(dev_wdata == ex, sw ? "R3" : "R6", dev_wdata, ex);
          advance();
        end
        nd++;
      end
    end
  end

  task automatic run_cfg(input bit d, input int mw, input int dw);
    int t;
    @(negedge clk);
    dir_in = d; mem_w = WW'(mw); dev_w = WW'(dw);
    b = dw / 8; sw = (mw == 32 && dw == 16);
    mdesc = 0; moff = 0; exp_links = 0; obs_links = 0; nd = 0; nw = 0; fidx = 0;
    #1;
    check(!cfg_err, "R2", {31'b0, cfg_err}, 0);
    check(swap == sw, "R3", {31'b0, swap}, {31'b0, sw});
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    check(busy && rd_req && rd_addr == BASE, "R4", rd_addr, BASE);
    check(dev_count == 0, "R9", dev_count, 0);
    t = 0;
    while (nd < 20 && t < 3000) begin @(negedge clk); t++; end
    abort_i = 1;
    @(negedge clk) abort_i = 0;
    t = 0;
    while (busy && t < 20) begin @(negedge clk); t++; end
    check(!busy, "R10", {31'b0, busy}, 0);
    repeat (8) @(negedge clk);
    check(dev_count == nd * b, "R9", dev_count, nd * b);
    check(obs_links == exp_links, "R8", obs_links, exp_links);
    check(exp_links >= 3, "R11", exp_links, 3);
  endtask

  initial begin
    int wl [6] = '{0, 8, 16, 24, 32, 48};
    repeat (3) @(negedge clk);
    check(!busy && !link_done && !rd_req && !wr_req && !dev_req, "R1", {28'b0, busy, rd_req, wr_req, dev_req}, 0);
    check(dev_count == 0, "R1", dev_count, 0);
    rst_n = 1;
    @(negedge clk);
    // width legality and swap sweep
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        bit lm, ld;
        mem_w = WW'(wl[i]); dev_w = WW'(wl[j]);
        #1;
        lm = wl[i] == 8 || wl[i] == 16 || wl[i] == 32;
        ld = wl[j] == 8 || wl[j] == 16 || wl[j] == 32;
        check(cfg_err == !(lm && ld), "R2", {31'b0, cfg_err}, {31'b0, !(lm && ld)});
        check(swap == (wl[i] == 32 && wl[j] == 16), "R3", {31'b0, swap}, {31'b0, (wl[i] == 32 && wl[j] == 16)});
      end
    end
    @(negedge clk);
    mem_w = 6'd24; dev_w = 6'd16;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    repeat (3) @(negedge clk);
    check(!busy && !rd_req, "R2", {31'b0, busy}, 0);
    for (int d = 0; d < 2; d++)
      for (int mi = 0; mi < 3; mi++)
        for (int di = 0; di < 3; di++)
          run_cfg(d[0], 8 << mi, 8 << di);
    summary();
    $finish;
  end
endmodule